// File: doc/BRIEF.md
# Flash Converter Output Back-End

This block is the digital half of a flash analog-to-digital converter. The comparator bank hands it a thermometer vector with one bit for each reference level. The block registers that vector, turns the lower levels into a binary code by counting the ones, and keeps the topmost comparator apart as an overflow flag. Two such converters can therefore be stacked for one extra bit of resolution. The code and flag travel through a short half-clock pipeline, so a sample taken on one clock edge shows up on the outputs one and a half periods later.

A polarity select chooses which clock level is the sampling phase. Two chip enables produce separate output-enable strobes for the data pads and the overflow pad. The pads themselves live outside the block, so the code and flag are always driven internally. A synchronous reset empties the pipeline.

Top module: `fbe_backend`

## Requirements
- R1: `code` equals the number of set bits among `levels[62:0]`, as an unsigned binary value with bit 5 as the MSB.
- R2: `ovf` equals `levels[63]` of the same sample.
- R3: With `phase_sel` = 0, `levels` is captured on a rising `clk` edge. The result updates `code`/`ovf` on the falling edge that follows the next rising edge (1.5 periods) and holds until the following falling edge.
- R4: With `phase_sel` = 1, the roles of the edges swap. Capture happens on a falling edge, and the outputs update on a rising edge 1.5 periods later.
- R5: All 64 levels set gives `code` = 63 with `ovf` = 1. All levels clear gives `code` = 0 with `ovf` = 0.
- R6: One cleared bit inside the run of ones, or one stray set bit above it in `levels[62:0]`, moves `code` by exactly one from the clean thermometer value.
- R7: `ce_all` = 0 forces `data_oe` = 0 and `ovf_oe` = 0. `ce_all` = 1 with `ce_data_n` = 1 gives `data_oe` = 0 and `ovf_oe` = 1. `ce_all` = 1 with `ce_data_n` = 0 gives both strobes 1.
- R8: While `rst` is high, every pipeline stage clears on each clock edge, so `code` = 0 and `ovf` = 0 whatever `levels` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_sel | input | 1 | 0: rising edge samples; 1: falling edge samples |
| levels | input | 64 | Comparator thermometer vector; bit 63 is the top level |
| ce_data_n | input | 1 | High floats the six data pads |
| ce_all | input | 1 | Low floats every pad |
| code | output | 6 | Encoded sample |
| ovf | output | 1 | Overflow flag |
| data_oe | output | 1 | Output enable for the data pads |
| ovf_oe | output | 1 | Output enable for the overflow pad |

## Verification
The checker assumes that a set top comparator always comes with a full, bubble-free set of lower levels. Under that assumption, a raised overflow flag can only pair with the all-ones code. The stimulus keeps to this rule: bubbles and stray bits are placed only in samples whose top level is clear. `phase_sel` changes only while reset is held, because flipping it mid-stream would add a spurious internal edge. The checker's flush property also expects zero levels to reach the outputs within three periods under either polarity.

// File: rtl/fbe_pkg.sv
`timescale 1ns/1ps
package fbe_pkg;

    // default comparator count; must be a power of two
    localparam int unsigned DEF_LEVELS = 64;

    // pad-enable modes decoded from the two chip enables
    typedef enum logic [1:0] {
        OE_DRIVE_ALL  = 2'd0,
        OE_FLAG_ONLY  = 2'd1,
        OE_FLOAT_ALL  = 2'd2
    } oe_mode_e;

endpackage

// File: rtl/fbe_thermo_enc.sv
`timescale 1ns/1ps
// Ones-count encoder: bubbles shift the result by one instead of scrambling it
module fbe_thermo_enc #(
    parameter int unsigned LEVELS = fbe_pkg::DEF_LEVELS,
    localparam int unsigned CODE_W = $clog2(LEVELS)
) (
    input  logic [LEVELS-2:0] lower,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < LEVELS - 1; i++) begin
            acc = acc + CODE_W'(lower[i]);
        end
    end

    assign code = acc;

endmodule

// File: rtl/fbe_pipe.sv
`timescale 1ns/1ps
// Half-clock pipeline: capture and count on the rising internal edge,
// present on the falling internal edge one period later.
module fbe_pipe #(
    parameter int unsigned LEVELS = fbe_pkg::DEF_LEVELS,
    localparam int unsigned CODE_W = $clog2(LEVELS)
) (
    input  logic              iclk,
    input  logic              rst,
    input  logic [LEVELS-1:0] levels,
    input  logic [CODE_W-1:0] enc_code,
    output logic [LEVELS-2:0] thermo_lo,
    output logic [CODE_W-1:0] code,
    output logic              ovf
);

    typedef struct packed {
        logic [LEVELS-1:0] thermo;
        logic [CODE_W-1:0] code;
        logic              ovf;
    } rise_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ovf;
    } fall_t;

    rise_t rise_d, rise_q;
    fall_t fall_d, fall_q;

    always_comb begin
        rise_d.thermo = levels;
        rise_d.code   = enc_code;
        rise_d.ovf    = rise_q.thermo[LEVELS-1];
        fall_d.code   = rise_q.code;
        fall_d.ovf    = rise_q.ovf;
        if (rst) begin
            rise_d = '0;
            fall_d = '0;
        end
    end

    always_ff @(posedge iclk) begin
        rise_q <= rise_d;
    end

    always_ff @(negedge iclk) begin
        fall_q <= fall_d;
    end

    assign thermo_lo = rise_q.thermo[LEVELS-2:0];
    assign code      = fall_q.code;
    assign ovf       = fall_q.ovf;

endmodule

// File: rtl/fbe_oe_ctrl.sv
`timescale 1ns/1ps
module fbe_oe_ctrl (
    input  logic ce_data_n,
    input  logic ce_all,
    output logic data_oe,
    output logic ovf_oe
);

    import fbe_pkg::*;

    oe_mode_e mode;

    always_comb begin
        if (!ce_all)        mode = OE_FLOAT_ALL;
        else if (ce_data_n) mode = OE_FLAG_ONLY;
        else                mode = OE_DRIVE_ALL;
    end

    always_comb begin
        data_oe = 1'b0;
        ovf_oe  = 1'b0;
        case (mode)
            OE_DRIVE_ALL: begin
                data_oe = 1'b1;
                ovf_oe  = 1'b1;
            end
            OE_FLAG_ONLY: ovf_oe = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fbe_backend.sv
`timescale 1ns/1ps
module fbe_backend #(
    parameter int unsigned LEVELS = fbe_pkg::DEF_LEVELS,
    localparam int unsigned CODE_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_sel,
    input  logic [LEVELS-1:0] levels,
    input  logic              ce_data_n,
    input  logic              ce_all,
    output logic [CODE_W-1:0] code,
    output logic              ovf,
    output logic              data_oe,
    output logic              ovf_oe
);

    // polarity select inverts the internal clock
    logic              iclk;
    logic [LEVELS-2:0] thermo_lo;
    logic [CODE_W-1:0] enc_code;

    assign iclk = clk ^ phase_sel;

    fbe_thermo_enc #(.LEVELS(LEVELS)) u_enc (
        .lower (thermo_lo),
        .code  (enc_code)
    );

    fbe_pipe #(.LEVELS(LEVELS)) u_pipe (
        .iclk      (iclk),
        .rst       (rst),
        .levels    (levels),
        .enc_code  (enc_code),
        .thermo_lo (thermo_lo),
        .code      (code),
        .ovf       (ovf)
    );

    fbe_oe_ctrl u_oe (
        .ce_data_n (ce_data_n),
        .ce_all    (ce_all),
        .data_oe   (data_oe),
        .ovf_oe    (ovf_oe)
    );

endmodule

// File: rtl/fbe_backend_chk.sv
`timescale 1ns/1ps
module fbe_backend_chk #(
    parameter int unsigned LEVELS = fbe_pkg::DEF_LEVELS,
    localparam int unsigned CODE_W = $clog2(LEVELS)
) (
    input logic              clk,
    input logic              rst,
    input logic [LEVELS-1:0] levels,
    input logic              ce_data_n,
    input logic              ce_all,
    input logic [CODE_W-1:0] code,
    input logic              ovf,
    input logic              data_oe,
    input logic              ovf_oe
);

    // R7
    float_all_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_all |-> (!data_oe && !ovf_oe));

    // R7
    flag_only_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_all && ce_data_n) |-> (!data_oe && ovf_oe));

    // R7
    drive_all_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_all && !ce_data_n) |-> (data_oe && ovf_oe));

    // R2 (relies on a set top level coming with a full lower run)
    ovf_full_code_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (&code));

    // R5 R3 R4
    zero_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (levels == '0 && $past(levels == '0) && $past(levels == '0, 2)
         && $past(levels == '0, 3)) |-> (code == '0 && !ovf));

endmodule

bind fbe_backend fbe_backend_chk #(.LEVELS(LEVELS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .levels    (levels),
    .ce_data_n (ce_data_n),
    .ce_all    (ce_all),
    .code      (code),
    .ovf       (ovf),
    .data_oe   (data_oe),
    .ovf_oe    (ovf_oe)
);

// File: tb/fbe_backend_test.sv
`timescale 1ns/1ps
module fbe_backend_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase_sel = 1'b0;
    logic [63:0] levels = '0;
    logic        ce_data_n = 1'b0;
    logic        ce_all = 1'b1;
    logic [5:0]  code;
    logic        ovf;
    logic        data_oe;
    logic        ovf_oe;

    int checks = 0;
    int fails  = 0;
    logic [63:0] hist [0:3];

    always #2 clk = ~clk;

    fbe_backend uut (
        .clk       (clk),
        .rst       (rst),
        .phase_sel (phase_sel),
        .levels    (levels),
        .ce_data_n (ce_data_n),
        .ce_all    (ce_all),
        .code      (code),
        .ovf       (ovf),
        .data_oe   (data_oe),
        .ovf_oe    (ovf_oe)
    );

    function automatic logic [63:0] therm(input int n);
        if (n == 0) return '0;
        return {64{1'b1}} >> (64 - n);
    endfunction

    function automatic int exp_code(input logic [63:0] v);
        return $countones(v[62:0]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one drive slot: early sample at +1, drive, late sample at +3
    task automatic slot(input logic [63:0] v, input int k, input string tag);
        logic [63:0] e;
        @(posedge clk);
        #1;
        e = phase_sel ? hist[1] : hist[2];
        check(phase_sel ? "R4 early code" : "R3 early code", code, exp_code(e));
        check(phase_sel ? "R4 early ovf" : "R3 early ovf", ovf, e[63]);
        levels    = v;
        ce_data_n = k[0];
        ce_all    = k[1];
        hist[3] = hist[2];
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = v;
        #2;
        check(tag, code, exp_code(hist[2]));
        check("R2 ovf", ovf, hist[2][63]);
        check("R7 data_oe", data_oe, k[1] & ~k[0]);
        check("R7 ovf_oe", ovf_oe, k[1]);
    endtask

    task automatic do_reset(input logic p);
        @(posedge clk);
        #1;
        rst = 1'b1;
        phase_sel = p;
        levels = '1;
        repeat (4) @(posedge clk);
        #3;
        check("R8 code in reset", code, 0);
        check("R8 ovf in reset", ovf, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        levels = '0;
        for (int i = 0; i < 4; i++) hist[i] = '0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) hist[i] = '0;
        for (int p = 0; p < 2; p++) begin
            do_reset(p[0]);
            for (int n = 0; n <= 64; n++)
                slot(therm(n), n, (n == 0 || n == 64) ? "R5 code" : "R1 code");
            for (int n = 64; n >= 0; n--)
                slot(therm(n), n + 1, (n == 0 || n == 64) ? "R5 code" : "R1 code");
            // R6 bubble inside the run (top level clear)
            for (int n = 2; n <= 63; n++) begin
                logic [63:0] v;
                v = therm(n);
                v[n / 2] = 1'b0;
                slot(v, n + 2, "R6 bubble code");
            end
            // R6 stray bit above the run
            for (int n = 0; n <= 61; n++) begin
                logic [63:0] v;
                v = therm(n);
                v[62] = 1'b1;
                slot(v, n + 3, "R6 stray code");
            end
            // R5 full-swing alternation
            for (int i = 0; i < 8; i++)
                slot(i[0] ? 64'd0 : {64{1'b1}}, i, "R5 code");
            for (int i = 0; i < 3; i++)
                slot('0, i, "R5 code");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule